// File: doc/BRIEF.md
# Parallel-to-Serial Pin Reduction Master

This block reduces pin count by taking a bus of parallel input bits, shifting it out as one SPI-like frame, and shifting a received frame in at the same time. The received frame is placed on a set of parallel outputs. It is the clocking side of the link: it drives the serial clock, an active-low chip select and the outgoing data line, and it samples the incoming data line. Timing is SPI mode 0. The clock idles low, a bit is driven when chip select falls and after every falling clock edge, and a bit is sampled on every rising edge.

A two-bit configuration input turns the block on only when it holds the active code. A selector picks one of several attribute sets. Each set holds a clock divider and a frame length, and the set is captured when a frame starts. A two-bit policy input decides when a frame starts. The block can run frames back to back, start one only when the inputs differ from the last frame sent, start one on an external trigger, or start one on a trigger only when the inputs have also changed.

Top module: `pinred_master`

## Requirements
- R1: After reset, csN is 1, sck is 0 and parOut is all zeros. The stored last-sent value is zero, so in change mode an all-zero masked input starts no frame.
- R2: When cfgMode is not 2'b01, no frame starts, and any trigger seen while disabled is dropped rather than kept pending.
- R3: With initMode 2'b00 (continuous), a new frame starts as soon as the previous inter-frame gap ends, for as long as the block is enabled.
- R4: A frame sends parIn bits [len-1:0] with bit len-1 first. mosi is set when csN falls and after each falling sck edge, and it does not change while sck is high.
- R5: miso is sampled on each rising sck edge. The first bit received ends up in parOut[len-1] and the last in parOut[0], and parOut bits at len and above are zero.
- R6: Between two frames, csN stays high for at least 2*div system clocks.
- R7: sck is low while csN is high. During a frame the sck period is 2*div system clocks, and a div value of 0 acts as 1. A frame has exactly len rising sck edges.
- R8: With initMode 2'b01 (change), a frame starts only when the masked parIn differs from the value sent in the last frame.
- R9: With initMode 2'b10 (trigger), a one-cycle trigIn pulse starts one frame. A pulse that arrives during a frame is held and starts one more frame after the gap.
- R10: With initMode 2'b11 (trigger and change), a trigger starts a frame only if the masked parIn differs from the last sent value. Otherwise the trigger is dropped. A change with no trigger starts nothing.
- R11: The frame length is taken from the attribute set, and values below 4 are raised to 4 and values above 16 are lowered to 16.
- R12: attrSel = k selects divider attrDiv[k*DIV_W +: DIV_W] and length attrLen[k*5 +: 5]. Both are captured at frame start.
- R13: parOut changes only in the cycle in which csN rises, with all bits updating together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Configuration field; 2'b01 enables the block |
| initMode | input | 2 | Frame start policy: 00 continuous, 01 change, 10 trigger, 11 trigger and change |
| attrSel | input | SEL_W | Attribute set selector |
| attrDiv | input | NUM_ATTR*DIV_W | Half-period divider for each set, in system clocks |
| attrLen | input | NUM_ATTR*5 | Frame length for each set |
| parIn | input | DATA_W | Parallel bits to send |
| trigIn | input | 1 | Frame trigger pulse |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock, idles low |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| parOut | output | DATA_W | Last received frame, right-aligned |

## Verification
The bench builds the block with DATA_W 16, NUM_ATTR 2 and DIV_W 4, so both the shortest and the longest frame length can be reached. Set 0 uses divider 1, which gives the tightest sck timing and the shortest gaps. Set 1 uses divider 3, and later the raw value 0, so the period check and the divide-by-zero rule each see a real case. Raw lengths of 2 and 31 drive the clamp at both ends. Switching attrSel between frames shows that each field comes from its own set.

// File: rtl/pinred_pkg.sv
package pinred_pkg;

  typedef enum logic [1:0] {
    INIT_CONT    = 2'b00,
    INIT_CHANGE  = 2'b01,
    INIT_TRIG    = 2'b10,
    INIT_TRIGCHG = 2'b11
  } initMode_e;

  localparam logic [1:0] CFG_ACTIVE = 2'b01;
  localparam int         MIN_LEN    = 4;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic load;    // capture parIn, clear receive register
    logic shift;   // advance transmit register (falling sck)
    logic sample;  // take miso (rising sck)
    logic commit;  // publish received frame on parOut
  } dpStrobe_t;

endpackage

// File: rtl/pinred_ctrl.sv
module pinred_ctrl
  import pinred_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_ATTR = 2,
  parameter int DIV_W    = 4,
  localparam int LEN_W   = $clog2(DATA_W + 1),
  localparam int SEL_W   = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                cfgMode,
  input  logic [1:0]                initMode,
  input  logic [SEL_W-1:0]          attrSel,
  input  logic [NUM_ATTR*DIV_W-1:0] attrDiv,
  input  logic [NUM_ATTR*LEN_W-1:0] attrLen,
  input  logic                      trigIn,
  input  logic                      dataDiffers,
  output logic                      sck,
  output logic                      csN,
  output dpStrobe_t                 strobe,
  output logic [LEN_W-1:0]          activeLen
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} state_e;

  state_e           state;
  logic [DIV_W:0]   halfCnt;
  logic [LEN_W-1:0] bitCnt;
  logic [DIV_W-1:0] curDiv;
  logic [LEN_W-1:0] curLen;
  logic             sckQ, csNQ, trigPend;

  logic [DIV_W-1:0] selDivRaw, selDiv;
  logic [LEN_W-1:0] selLenRaw, selLen;
  logic enabled, trigAny, go, startNow, consume, halfDone;

  // pick the attribute set
  always_comb begin
    selDivRaw = '0;
    selLenRaw = '0;
    for (int k = 0; k < NUM_ATTR; k++) begin
      if (attrSel == SEL_W'(k)) begin
        selDivRaw = attrDiv[k*DIV_W +: DIV_W];
        selLenRaw = attrLen[k*LEN_W +: LEN_W];
      end
    end
    selDiv = (selDivRaw == '0) ? DIV_W'(1) : selDivRaw;
    if (selLenRaw < LEN_W'(MIN_LEN))     selLen = LEN_W'(MIN_LEN);
    else if (selLenRaw > LEN_W'(DATA_W)) selLen = LEN_W'(DATA_W);
    else                                 selLen = selLenRaw;
  end

  always_comb begin
    enabled = (cfgMode == CFG_ACTIVE);
    trigAny = trigPend | trigIn;
    case (initMode_e'(initMode))
      INIT_CONT:    go = 1'b1;
      INIT_CHANGE:  go = dataDiffers;
      INIT_TRIG:    go = trigAny;
      INIT_TRIGCHG: go = trigAny & dataDiffers;
      default:      go = 1'b0;
    endcase
    startNow = (state == ST_IDLE) && enabled && go;
    consume  = (state == ST_IDLE) && enabled && initMode[1] && trigAny;
    halfDone = (halfCnt == '0);

    strobe.load   = startNow;
    strobe.sample = (state == ST_RUN) && halfDone && !sckQ;
    strobe.shift  = (state == ST_RUN) && halfDone && sckQ && (bitCnt != '0);
    strobe.commit = (state == ST_RUN) && halfDone && sckQ && (bitCnt == '0);

    activeLen = (state == ST_IDLE) ? selLen : curLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      bitCnt   <= '0;
      curDiv   <= DIV_W'(1);
      curLen   <= LEN_W'(MIN_LEN);
      sckQ     <= 1'b0;
      csNQ     <= 1'b1;
      trigPend <= 1'b0;
    end else begin
      if (!enabled || consume) trigPend <= 1'b0;
      else                     trigPend <= trigPend | trigIn;

      case (state)
        ST_IDLE: begin
          if (startNow) begin
            state   <= ST_RUN;
            csNQ    <= 1'b0;
            sckQ    <= 1'b0;
            curDiv  <= selDiv;
            curLen  <= selLen;
            halfCnt <= {1'b0, selDiv} - (DIV_W+1)'(1);
            bitCnt  <= selLen - LEN_W'(1);
          end
        end
        ST_RUN: begin
          if (!halfDone) begin
            halfCnt <= halfCnt - (DIV_W+1)'(1);
          end else if (!sckQ) begin
            sckQ    <= 1'b1;
            halfCnt <= {1'b0, curDiv} - (DIV_W+1)'(1);
          end else begin
            sckQ <= 1'b0;
            if (bitCnt == '0) begin
              state   <= ST_GAP;
              csNQ    <= 1'b1;
              halfCnt <= {curDiv, 1'b0} - (DIV_W+1)'(1);
            end else begin
              bitCnt  <= bitCnt - LEN_W'(1);
              halfCnt <= {1'b0, curDiv} - (DIV_W+1)'(1);
            end
          end
        end
        ST_GAP: begin
          if (halfDone) state <= ST_IDLE;
          else          halfCnt <= halfCnt - (DIV_W+1)'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sck = sckQ;
  assign csN = csNQ;

endmodule

// File: rtl/pinred_dp.sv
module pinred_dp
  import pinred_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [LEN_W-1:0]  activeLen,
  input  logic [DATA_W-1:0] parIn,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] parOut,
  output logic              dataDiffers
);

  logic [DATA_W-1:0] txShift, rxShift, lastTx, lenMask;
  logic              mosiBit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lenMask[i] = (LEN_W'(i) < activeLen);
  end

  // top bit of the active window goes out first
  always_comb begin
    mosiBit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i + 1) == activeLen) mosiBit = txShift[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      lastTx  <= '0;
      parOut  <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= parIn & lenMask;
        lastTx  <= parIn & lenMask;
        rxShift <= '0;
      end
      if (strobe.shift)  txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strobe.sample) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (strobe.commit) parOut  <= rxShift & lenMask;
    end
  end

  assign mosi        = mosiBit;
  assign dataDiffers = ((parIn & lenMask) != lastTx);

endmodule

// File: rtl/pinred_master.sv
module pinred_master
  import pinred_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_ATTR = 2,
  parameter int DIV_W    = 4,
  localparam int LEN_W   = $clog2(DATA_W + 1),
  localparam int SEL_W   = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                cfgMode,
  input  logic [1:0]                initMode,
  input  logic [SEL_W-1:0]          attrSel,
  input  logic [NUM_ATTR*DIV_W-1:0] attrDiv,
  input  logic [NUM_ATTR*LEN_W-1:0] attrLen,
  input  logic [DATA_W-1:0]         parIn,
  input  logic                      trigIn,
  input  logic                      miso,
  output logic                      sck,
  output logic                      csN,
  output logic                      mosi,
  output logic [DATA_W-1:0]         parOut
);

  dpStrobe_t        strobe;
  logic [LEN_W-1:0] activeLen;
  logic             dataDiffers;

  pinred_ctrl #(.DATA_W(DATA_W), .NUM_ATTR(NUM_ATTR), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .initMode(initMode),
    .attrSel(attrSel), .attrDiv(attrDiv), .attrLen(attrLen), .trigIn(trigIn),
    .dataDiffers(dataDiffers), .sck(sck), .csN(csN), .strobe(strobe),
    .activeLen(activeLen)
  );

  pinred_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .activeLen(activeLen),
    .parIn(parIn), .miso(miso), .mosi(mosi), .parOut(parOut),
    .dataDiffers(dataDiffers)
  );

endmodule

// File: rtl/pinred_master_chk.sv
module pinred_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        cfgMode,
  input logic              csN,
  input logic              sck,
  input logic              mosi,
  input logic [DATA_W-1:0] parOut
);

  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && cfgMode != 2'b01) |=> csN);  // R2

  AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);  // R7

  AST_MOSI_CHANGES_LOW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$stable(mosi)) |-> !sck);  // R4

  AST_GAP_AT_LEAST_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);  // R6

  AST_PAROUT_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(parOut) |-> $rose(csN));  // R13

endmodule

bind pinred_master pinred_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .csN(csN), .sck(sck),
  .mosi(mosi), .parOut(parOut)
);

// File: tb/tb_pinred_master.sv
module tb_pinred_master;

  localparam int DATA_W   = 16;
  localparam int NUM_ATTR = 2;
  localparam int DIV_W    = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [1:0]           cfgMode = 2'b00;
  logic [1:0]           initMode = 2'b00;
  logic [0:0]           attrSel = 1'b0;
  logic [2*DIV_W-1:0]   attrDiv = {4'd3, 4'd1};
  logic [2*5-1:0]       attrLen = {5'd16, 5'd8};
  logic [DATA_W-1:0]    parIn = '0;
  logic                 trigIn = 1'b0;
  logic                 miso = 1'b0;
  logic                 sck, csN, mosi;
  logic [DATA_W-1:0]    parOut;

  pinred_master #(.DATA_W(DATA_W), .NUM_ATTR(NUM_ATTR), .DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .initMode(initMode),
    .attrSel(attrSel), .attrDiv(attrDiv), .attrLen(attrLen), .parIn(parIn),
    .trigIn(trigIn), .miso(miso), .sck(sck), .csN(csN), .mosi(mosi),
    .parOut(parOut)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    logic [DATA_W-1:0] tx;
    logic [DATA_W-1:0] slv;
    int                len;
    int                div;
  } item_t;

  item_t sbQ[$];
  int nChecks = 0;
  int nFail = 0;
  int framesDone = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] maskOf(input int len);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < len; i++) m[i] = 1'b1;
    return m;
  endfunction

  // monitor and slave model
  item_t cur;
  bit    prevCs = 1, prevSck = 0, parMoved = 0;
  logic [DATA_W-1:0] rcv, parAtStart;
  int rises = 0, bitIdx = 0, sinceRise = 0, gapCnt = 0, lastDiv = 1;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCs = 1; prevSck = 0;
    end else begin
      if (prevCs && !csN) begin
        if (sbQ.size() == 0) begin
          chk(0, "R3", "unexpected frame start", 1, 0);
          cur = '{tx: '0, slv: '0, len: 4, div: 1};
        end else begin
          cur = sbQ.pop_front();
        end
        if (framesDone > 0)
          chk(gapCnt >= 2*lastDiv, "R6", "gap cycles", gapCnt, 2*lastDiv);
        parAtStart = parOut; parMoved = 0;
        rcv = '0; rises = 0; sinceRise = 0;
        bitIdx = cur.len - 1;
        miso = cur.slv[bitIdx];
      end
      if (!csN) begin
        if (!prevSck && sck) begin
          rcv = {rcv[DATA_W-2:0], mosi};
          rises++;
          if (rises > 1)
            chk(sinceRise == 2*cur.div, "R7", "sck period", sinceRise, 2*cur.div);
          sinceRise = 0;
        end
        if (prevSck && !sck) begin
          if (bitIdx > 0) bitIdx--;
          miso = cur.slv[bitIdx];
        end
        if (parOut != parAtStart) parMoved = 1;
        sinceRise++;
      end
      if (!prevCs && csN) begin
        chk(rcv == cur.tx, "R4", "bits sent MSB first", rcv, cur.tx);
        chk(rises == cur.len, "R7", "rising edges per frame", rises, cur.len);
        chk(parOut == (cur.slv & maskOf(cur.len)), "R5", "parOut after frame",
            parOut, cur.slv & maskOf(cur.len));
        chk(!parMoved, "R13", "parOut moved during frame", parMoved, 0);
        framesDone++;
        gapCnt = 0;
        lastDiv = cur.div;
      end
      if (csN) gapCnt++;
      prevCs = csN; prevSck = sck;
    end
  end

  task automatic pushItem(input logic [DATA_W-1:0] tx, input logic [DATA_W-1:0] slv,
                          input int len, input int div);
    item_t it;
    it.tx = tx & maskOf(len); it.slv = slv & maskOf(len);
    it.len = len; it.div = div;
    sbQ.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseTrig();
    @(posedge clk); #1 trigIn = 1'b1;
    @(posedge clk); #1 trigIn = 1'b0;
  endtask

  task automatic waitFrames(input int n);
    wait (framesDone >= n);
    idle(1);
  endtask

  initial begin
    idle(5);
    @(negedge clk);
    chk(csN == 1'b1, "R1", "csN in reset", csN, 1);
    chk(sck == 1'b0, "R1", "sck in reset", sck, 0);
    chk(parOut == '0, "R1", "parOut in reset", parOut, 0);
    idle(1);
    rstN = 1'b1;

    // R1: last-sent starts at zero; masked input 0 sends nothing
    parIn = 16'hFF00; initMode = 2'b01; cfgMode = 2'b01;
    idle(40);
    chk(framesDone == 0, "R1", "change mode frames with zero input", framesDone, 0);

    // R2: disabled codes
    cfgMode = 2'b10; initMode = 2'b00;
    idle(40);
    chk(framesDone == 0, "R2", "frames with cfgMode 10", framesDone, 0);
    cfgMode = 2'b00;
    idle(40);
    chk(framesDone == 0, "R2", "frames with cfgMode 00", framesDone, 0);
    initMode = 2'b10;
    pulseTrig();
    idle(2);
    cfgMode = 2'b01;
    idle(40);
    chk(framesDone == 0, "R2", "trigger held while disabled", framesDone, 0);
    cfgMode = 2'b00;

    // R3: continuous
    parIn = 16'h00A5;
    pushItem(16'hA5, 16'h3C, 8, 1);
    pushItem(16'hA5, 16'hC3, 8, 1);
    pushItem(16'hA5, 16'h5A, 8, 1);
    initMode = 2'b00; cfgMode = 2'b01;
    wait (sbQ.size() == 0);
    idle(1);
    cfgMode = 2'b00;
    waitFrames(3);
    idle(30);
    chk(framesDone == 3, "R3", "continuous frame count", framesDone, 3);

    // R8: change mode
    initMode = 2'b01; cfgMode = 2'b01;
    idle(40);
    chk(framesDone == 3, "R8", "no frame on unchanged input", framesDone, 3);
    pushItem(16'h5A, 16'h81, 8, 1);
    parIn = 16'h005A;
    waitFrames(4);
    idle(40);
    chk(framesDone == 4, "R8", "one frame per change", framesDone, 4);

    // R9: trigger mode, including trigger during a frame
    initMode = 2'b10;
    idle(1);
    parIn = 16'h0077;
    pushItem(16'h77, 16'h11, 8, 1);
    pulseTrig();
    waitFrames(5);
    pushItem(16'h77, 16'h22, 8, 1);
    pushItem(16'h77, 16'h33, 8, 1);
    pulseTrig();
    wait (!csN);
    idle(2);
    pulseTrig();
    waitFrames(7);
    idle(40);
    chk(framesDone == 7, "R9", "frames from two triggers", framesDone, 7);

    // R10: trigger and change
    initMode = 2'b11;
    pulseTrig();
    idle(40);
    chk(framesDone == 7, "R10", "trigger without change dropped", framesDone, 7);
    parIn = 16'h0099;
    idle(40);
    chk(framesDone == 7, "R10", "change without trigger", framesDone, 7);
    pushItem(16'h99, 16'h44, 8, 1);
    pulseTrig();
    waitFrames(8);
    idle(40);
    chk(framesDone == 8, "R10", "trigger with change", framesDone, 8);

    // R12: attribute set 1 (div 3, len 16)
    initMode = 2'b10;
    parIn = 16'hBEEF;
    attrSel = 1'b1;
    pushItem(16'hBEEF, 16'h1234, 16, 3);
    pulseTrig();
    waitFrames(9);
    idle(20);
    chk(framesDone == 9, "R12", "set 1 frame", framesDone, 9);

    // R11: raw length 2 clamps to 4
    attrLen = {5'd16, 5'd2};
    attrSel = 1'b0;
    parIn = 16'h00FD;
    pushItem(16'h000D, 16'h0006, 4, 1);
    pulseTrig();
    waitFrames(10);

    // R11 / R7: raw length 31 clamps to 16, raw div 0 acts as 1
    attrLen = {5'd31, 5'd2};
    attrDiv = {4'd0, 4'd1};
    attrSel = 1'b1;
    parIn = 16'hC001;
    pushItem(16'hC001, 16'h8001, 16, 1);
    pulseTrig();
    waitFrames(11);
    idle(40);
    chk(framesDone == 11, "R11", "total frames", framesDone, 11);
    chk(sbQ.size() == 0, "R9", "scoreboard drained", sbQ.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule